// File: doc/BRIEF.md
# Transmit Clock Activity Monitor

This block watches one transmit channel's clock and its negative-rail data input, and decides how the channel driver should behave. A transmit clock stuck high switches the channel to sending a continuous all-ones pattern. A transmit clock stuck low powers the channel down and turns its driver off. The stuck time is measured in edges of a reference clock. That reference is normally the master clock. When the master clock is reported inactive, a second channel's transmit clock takes its place. If that second clock has also stopped, every driver goes to high impedance. A separate detector selects single-rail mode 1 while the negative-rail pin stays high over a long run of transmit clock cycles.

Every input is asynchronous to a fast sampling clock `clk`. All five inputs pass through one multi-stage synchronizer. The edges of the three clocks are found in the `clk` domain. Each threshold is a parameter. The driver enable stands in for tri-stating the analog output. `ones_o` pulses once for each rising edge of the selected reference while the channel sends all-ones.

Top module: `tx_clk_monitor`

## Requirements
- R1: After reset, `state_o` is 0 (normal), `drv_en_o` is 1, and `sr1_o` and `ones_o` are 0.
- R2: When the synchronized transmit clock stays high for more than HI_LIMIT (16) rising edges of the selected reference, `state_o` becomes 1 (all-ones). At 16 or fewer such edges it stays 0.
- R3: When the transmit clock stays low for LO_LIMIT (64) reference rising edges, `state_o` becomes 2 (power-down) and `drv_en_o` drops to 0. Fewer edges leave the channel in normal operation.
- R4: While `state_o` is 1, `ones_o` is high for exactly one `clk` cycle per rising edge of the selected reference. In every other state it is 0.
- R5: The reference is the master clock while `mclk_alive_i` is 1, and the second channel clock `refclk_i` while it is 0. The same thresholds apply to both.
- R6: When `mclk_alive_i` is 0 and `refclk_i` has shown no edge for REF_TIMEOUT (64) `clk` cycles, `state_o` is 3 (all drivers high impedance) and `drv_en_o` is 0.
- R7: Every detected transmit clock edge clears both stuck counters. A running transmit clock therefore returns the channel to state 0 within six `clk` cycles.
- R8: `sr1_o` goes to 1 once `tdn_i` has been high for more than SR_LIMIT (16) consecutive transmit clock rising edges.
- R9: `sr1_o` returns to 0 three `clk` cycles after `tdn_i` goes low.
- R10: State priority runs high-impedance (3), then power-down (2), then all-ones (1), then normal (0). Exactly one of `tao_o`, `pdn_o` and `hiz_o` is high in states 1, 2 and 3, and none is high in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_i | input | 1 | Master clock, sampled |
| mclk_alive_i | input | 1 | 1 when the master clock is running |
| refclk_i | input | 1 | Fallback reference: another channel's transmit clock |
| tclk_i | input | 1 | This channel's transmit clock |
| tdn_i | input | 1 | Negative-rail data pin |
| state_o | output | 2 | 0 normal, 1 all-ones, 2 power-down, 3 all high-Z |
| tao_o | output | 1 | All-ones state flag |
| pdn_o | output | 1 | Power-down state flag |
| hiz_o | output | 1 | All-transmitters high-impedance flag |
| drv_en_o | output | 1 | Line driver enable (0 = high impedance) |
| sr1_o | output | 1 | Single-rail mode 1 selected |
| ones_o | output | 1 | All-ones strobe, one pulse per reference rising edge |

## Verification
A stuck counter that misses an edge, or misses a clear, moves the all-ones or power-down decision by whole reference periods. The state output shows this within one `clk` cycle of the threshold crossing. Selecting the wrong reference changes the spacing of `ones_o` pulses, so the count taken over a fixed window differs from the expected count. A missing clear shows up as a late return to state 0 after the transmit clock restarts, or as `sr1_o` staying high after `tdn_i` falls. The per-cycle comparison catches these errors in the first cycle the outputs diverge.

// File: rtl/txmon_pkg.sv
package txmon_pkg;

   typedef enum logic [1:0] {
      TXM_NORMAL     = 2'd0,
      TXM_ALL_ONES   = 2'd1,
      TXM_POWER_DOWN = 2'd2,
      TXM_ALL_HIZ    = 2'd3
   } txm_state_e;

endpackage

// File: rtl/txmon_sync.sv
module txmon_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("txmon_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("txmon_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/txmon_run_cnt.sv
module txmon_run_cnt #(
   parameter int unsigned SAT = 17,
   localparam int unsigned W  = $clog2(SAT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic full
);

   if (SAT < 1) begin : g_bad_sat
      $error("txmon_run_cnt: SAT must be at least 1");
   end

   localparam logic [W-1:0] SAT_V = W'(SAT);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (clr)                      cnt_q <= '0;
      else if (inc && (cnt_q != SAT_V))  cnt_q <= cnt_q + W'(1);
   end

   assign full = (cnt_q == SAT_V);

   // R2: the counter saturates and never passes its limit
   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= SAT_V);

   // R7: a clear request empties the counter on the next cycle
   assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

endmodule

// File: rtl/tx_clk_monitor.sv
module tx_clk_monitor
   import txmon_pkg::*;
#(
   parameter int unsigned HI_LIMIT    = 16,
   parameter int unsigned LO_LIMIT    = 64,
   parameter int unsigned SR_LIMIT    = 16,
   parameter int unsigned REF_TIMEOUT = 64,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mclk_i,
   input  logic       mclk_alive_i,
   input  logic       refclk_i,
   input  logic       tclk_i,
   input  logic       tdn_i,
   output logic [1:0] state_o,
   output logic       tao_o,
   output logic       pdn_o,
   output logic       hiz_o,
   output logic       drv_en_o,
   output logic       sr1_o,
   output logic       ones_o
);

   if (HI_LIMIT < 1 || LO_LIMIT < 1 || SR_LIMIT < 1) begin : g_bad_limits
      $error("tx_clk_monitor: thresholds must be at least 1");
   end
   if (REF_TIMEOUT < 2) begin : g_bad_timeout
      $error("tx_clk_monitor: REF_TIMEOUT must be at least 2");
   end

   // synchronized input vector layout
   localparam int unsigned NSIG    = 5;
   localparam int unsigned IX_MACT = 0;
   localparam int unsigned IX_MCLK = 1;
   localparam int unsigned IX_TCLK = 3;
   localparam int unsigned IX_TDN  = 4;
   // clock group layout (edge tracked)
   localparam int unsigned NCK     = IX_TCLK - IX_MCLK + 1;
   localparam int unsigned CK_M    = 0;
   localparam int unsigned CK_R    = 1;
   localparam int unsigned CK_T    = 2;
   localparam int unsigned HI_SAT  = HI_LIMIT + 1;
   localparam int unsigned SR_SAT  = SR_LIMIT + 1;

   logic [NSIG-1:0] raw_in, lvl;
   logic [NCK-1:0]  ck_now, ck_last, ck_chg, ck_rise;
   logic            mclk_ok, tdn_hi, ref_tick;
   logic            hi_full, lo_full, sr_full, ref_dead;
   txm_state_e      st;

   assign raw_in = {tdn_i, tclk_i, refclk_i, mclk_i, mclk_alive_i};

   txmon_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (lvl)
   );

   assign mclk_ok = lvl[IX_MACT];
   assign tdn_hi  = lvl[IX_TDN];
   assign ck_now  = lvl[IX_TCLK:IX_MCLK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ck_last <= '0;
      else        ck_last <= ck_now;
   end

   assign ck_chg  = ck_now ^ ck_last;
   assign ck_rise = ck_chg & ck_now;

   // reference selection: master clock, else the fallback channel clock
   assign ref_tick = mclk_ok ? ck_rise[CK_M] : ck_rise[CK_R];

   txmon_run_cnt #(.SAT(HI_SAT)) u_hi_run (
      .clk (clk), .rst_n (rst_n),
      .clr (ck_chg[CK_T]),
      .inc (ref_tick & ck_now[CK_T]),
      .full(hi_full)
   );

   txmon_run_cnt #(.SAT(LO_LIMIT)) u_lo_run (
      .clk (clk), .rst_n (rst_n),
      .clr (ck_chg[CK_T]),
      .inc (ref_tick & ~ck_now[CK_T]),
      .full(lo_full)
   );

   txmon_run_cnt #(.SAT(SR_SAT)) u_sr_run (
      .clk (clk), .rst_n (rst_n),
      .clr (~tdn_hi),
      .inc (ck_rise[CK_T]),
      .full(sr_full)
   );

   txmon_run_cnt #(.SAT(REF_TIMEOUT)) u_ref_watch (
      .clk (clk), .rst_n (rst_n),
      .clr (ck_chg[CK_R]),
      .inc (1'b1),
      .full(ref_dead)
   );

   always_comb begin
      if (!mclk_ok && ref_dead) st = TXM_ALL_HIZ;
      else if (lo_full)         st = TXM_POWER_DOWN;
      else if (hi_full)         st = TXM_ALL_ONES;
      else                      st = TXM_NORMAL;
   end

   assign state_o  = st;
   assign tao_o    = (st == TXM_ALL_ONES);
   assign pdn_o    = (st == TXM_POWER_DOWN);
   assign hiz_o    = (st == TXM_ALL_HIZ);
   assign drv_en_o = ~(pdn_o | hiz_o);
   assign sr1_o    = sr_full;
   assign ones_o   = tao_o & ref_tick;

   // R2: the high-run limit is only reached with the clock seen high
   assert_tao_needs_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hi_full |-> $past(ck_now[CK_T]));

   // R3: the low-run limit is only reached with the clock seen low
   assert_pdn_needs_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lo_full |-> !$past(ck_now[CK_T]));

   // R4: strobes come from rising edges, so two never touch unless the reference changed
   assert_ones_spaced_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ones_o |=> (!ones_o || (mclk_ok != $past(mclk_ok))));

   // R7: a transmit clock edge leaves neither stuck limit reached
   assert_edge_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ck_chg[CK_T] |=> (!hi_full && !lo_full));

   // R9: a low negative-rail level drops single-rail mode on the next cycle
   assert_sr1_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !tdn_hi |=> !sr1_o);

   // R10: at most one state flag at a time
   assert_flags_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tao_o, pdn_o, hiz_o}));

endmodule

// File: tb/tx_clk_monitor_bench.sv
module tx_clk_monitor_bench;

   localparam int HI = 16;
   localparam int LO = 64;
   localparam int SR = 16;
   localparam int RT = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mclk = 1'b0, mact = 1'b0, rclk = 1'b0, tclk = 1'b0, tdn = 1'b0;
   logic [1:0] state_o;
   logic tao_o, pdn_o, hiz_o, drv_en_o, sr1_o, ones_o;

   always #4 clk = ~clk;   // 125 MHz

   tx_clk_monitor u_tx_clk_monitor (
      .clk(clk), .rst_n(rst_n), .mclk_i(mclk), .mclk_alive_i(mact),
      .refclk_i(rclk), .tclk_i(tclk), .tdn_i(tdn),
      .state_o(state_o), .tao_o(tao_o), .pdn_o(pdn_o), .hiz_o(hiz_o),
      .drv_en_o(drv_en_o), .sr1_o(sr1_o), .ones_o(ones_o)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // stimulus requests, applied on falling edges
   int m_run = 0, r_run = 0, t_mode = 2;   // t_mode: 0 toggle, 1 high, 2 low
   logic req_mact = 1'b0, req_tdn = 1'b0;
   int mcnt = 0, rcnt = 0, tcnt = 0;

   always @(negedge clk) begin
      mact = req_mact;
      tdn  = req_tdn;
      if (m_run != 0) begin mcnt++; if (mcnt >= 2) begin mcnt = 0; mclk = ~mclk; end end
      if (r_run != 0) begin rcnt++; if (rcnt >= 3) begin rcnt = 0; rclk = ~rclk; end end
      case (t_mode)
         0: begin tcnt++; if (tcnt >= 2) begin tcnt = 0; tclk = ~tclk; end end
         1: tclk = 1'b1;
         default: tclk = 1'b0;
      endcase
   end

   // reference model: input history plus run lengths in reference edges
   logic [3:0] hm, hmc, hr, ht, hd;
   int m_hi = 0, m_lo = 0, m_sr = 0, m_rd = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         hm = '0; hmc = '0; hr = '0; ht = '0; hd = '0;
         m_hi = 0; m_lo = 0; m_sr = 0; m_rd = 0;
      end else begin
         logic tick, tedge;
         hm  = {hm[2:0], mact};
         hmc = {hmc[2:0], mclk};
         hr  = {hr[2:0], rclk};
         ht  = {ht[2:0], tclk};
         hd  = {hd[2:0], tdn};
         tick  = hm[2] ? (hmc[2] & ~hmc[3]) : (hr[2] & ~hr[3]);
         tedge = ht[2] ^ ht[3];
         if (tedge) begin m_hi = 0; m_lo = 0; end
         else if (tick) begin
            if (ht[2] && m_hi < HI + 1) m_hi++;
            if (!ht[2] && m_lo < LO) m_lo++;
         end
         if (!hd[2]) m_sr = 0;
         else if (ht[2] && !ht[3] && m_sr < SR + 1) m_sr++;
         if (hr[2] != hr[3]) m_rd = 0;
         else if (m_rd < RT) m_rd++;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         int est;
         logic tick_n;
         est = (!hm[1] && m_rd == RT) ? 3 : (m_lo == LO) ? 2 : (m_hi == HI + 1) ? 1 : 0;
         tick_n = hm[1] ? (hmc[1] & ~hmc[2]) : (hr[1] & ~hr[2]);
         check("R10 state", int'(state_o), est);
         check("R10 flags", int'({hiz_o, pdn_o, tao_o}),
               (est == 1) ? 1 : (est == 2) ? 2 : (est == 3) ? 4 : 0);
         check("R3/R6 drv_en", int'(drv_en_o), (est >= 2) ? 0 : 1);
         check("R4 ones", int'(ones_o), (est == 1 && tick_n) ? 1 : 0);
         check("R8 sr1", int'(sr1_o), (m_sr == SR + 1) ? 1 : 0);
      end
   end

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc > 100000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
         finish_run();
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic count_ones(input int n, output int got);
      got = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (ones_o) got++;
      end
   endtask

   initial begin
      int n;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 state", int'(state_o), 0);
      check("R1 drv_en", int'(drv_en_o), 1);
      check("R1 sr1", int'(sr1_o), 0);
      check("R1 ones", int'(ones_o), 0);

      // running clocks, master present
      @(posedge clk); req_mact = 1'b1; m_run = 1; r_run = 1; t_mode = 0;
      wait_cyc(200);
      check("R7 normal with running clock", int'(state_o), 0);

      // R2: stuck high, below and above threshold
      @(posedge clk); t_mode = 1;
      wait_cyc(40);
      check("R2 below limit", int'(state_o), 0);
      wait_cyc(100);
      check("R2 all-ones", int'(state_o), 1);
      check("R2 tao flag", int'(tao_o), 1);
      // R4/R5: strobes follow master clock (period 4)
      count_ones(40, n);
      check("R4 strobes per master edge", n, 10);

      // R7: restart clears
      @(posedge clk); t_mode = 0;
      wait_cyc(8);
      check("R7 back to normal", int'(state_o), 0);

      // R3: stuck low
      @(posedge clk); t_mode = 2;
      wait_cyc(40);
      check("R3 below limit", int'(state_o), 0);
      check("R3 driver still on", int'(drv_en_o), 1);
      wait_cyc(260);
      check("R3 power-down", int'(state_o), 2);
      check("R3 driver off", int'(drv_en_o), 0);

      // R5: master inactive, fallback clock (period 6) times everything
      @(posedge clk); req_mact = 1'b0; t_mode = 1;
      wait_cyc(200);
      check("R5 all-ones via fallback", int'(state_o), 1);
      count_ones(60, n);
      check("R5 strobes per fallback edge", n, 10);

      // R6: fallback also stops; high impedance overrides all-ones
      @(posedge clk); r_run = 0;
      wait_cyc(40);
      check("R6 before timeout", int'(state_o), 1);
      wait_cyc(60);
      check("R6 all high-Z", int'(state_o), 3);
      check("R6 driver off", int'(drv_en_o), 0);
      check("R10 hiz flag", int'(hiz_o), 1);
      count_ones(20, n);
      check("R4 no strobes outside all-ones", n, 0);

      // restore
      @(posedge clk); req_mact = 1'b1; r_run = 1; t_mode = 0;
      wait_cyc(20);
      check("R7 normal after restore", int'(state_o), 0);

      // R8: negative-rail held high
      @(posedge clk); req_tdn = 1'b1;
      wait_cyc(40);
      check("R8 below limit", int'(sr1_o), 0);
      wait_cyc(60);
      check("R8 single-rail mode 1", int'(sr1_o), 1);

      // R9: drop clears after three cycles
      @(posedge clk); req_tdn = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9 sr1 cleared", int'(sr1_o), 0);

      wait_cyc(20);
      finish_run();
   end

endmodule